// File: doc/BRIEF.md
# Prefetch Fault Status Tracker

This block follows bus-error status for a two-entry instruction prefetch queue, whose entries are called stage B and stage C, and for the most recent data bus cycle. Each stage carries two flags. The rerun flag records that the prefetch which filled the stage came back with a bus error. The fault flag records that the decoder later tried to consume that invalid stage. When a bus fault exception is taken, a capture strobe freezes these flags and the data-cycle attributes into a 16-bit status word that the exception logic can stack.

On exception return, the four stacked stage flags are restored together with the stacked privilege bit. The restored flags set how each stage is refilled. If both flags of a stage are set, the block requests a refetch at once. If only the rerun flag is set, it waits until the decoder asks for that stage. If the rerun flag is clear, the stage counts as valid and no bus cycle is needed. Refetch requests leave on a valid/ready port. Each carries the stage and the program-space function code for the restored privilege level.

Top module: `pf_fault_tracker`

## Requirements
- R1: After reset the status word output is 0x0000 and no refetch request is offered.
- R2: A prefetch completion with an error for a stage sets that stage's rerun flag (bit 12 for stage B, bit 13 for stage C) and leaves its fault flag clear. Stage encoding on every stage port is 0 = B, 1 = C.
- R3: A consume request to a stage that holds an errored prefetch sets that stage's fault flag (bit 14 for B, bit 15 for C), and the rerun flag stays set.
- R4: An error-free prefetch completion into a stage clears that stage's fault flag, its rerun flag and its invalid mark.
- R5: The status word packs the last latched data-cycle attributes as follows: data fault at bit 8, read-modify-write at bit 7, read/write at bit 6 (1 = read), size at bits 5:4 and function code at bits 2:0. Bits 11:9 and bit 3 are zero. A capture makes the word visible on the next cycle, and the word then holds until the next capture. The word reflects the state from before any update made in the capture cycle.
- R6: A restore in which a stage's flag pair is fault=1 and rerun=1 offers a refetch of that stage on the second cycle after the restore, with no consume request needed. The restore flags input carries word bits 15:12 at positions 3:0.
- R7: A restore with rerun=1 and fault=0 for a stage offers no request until a consume request to that stage arrives. The offer appears on the second cycle after that consume request.
- R8: A restore with rerun=0 marks the stage valid. No request follows, and a later consume request sets no fault flag.
- R9: The refetch function code is 3'b110 when the stacked privilege bit was 1 (supervisor program) and 3'b010 when it was 0 (user program).
- R10: When both stages await a refetch, stage C is offered before stage B.
- R11: An offered request keeps its valid, stage and function code unchanged until ready is seen high.
- R12: A fault flag is never reported without its rerun flag. A restored fault flag whose rerun flag is clear is treated as clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_done | input | 1 | Prefetch completion strobe |
| pf_err | input | 1 | Completion ended in a bus error |
| pf_stage | input | 1 | Stage filled (0 = B, 1 = C) |
| use_req | input | 1 | Decoder consume request |
| use_stage | input | 1 | Stage consumed (0 = B, 1 = C) |
| dc_valid | input | 1 | Latch the data-cycle attributes |
| dc_fault | input | 1 | Data cycle faulted or needs rerun |
| dc_rmw | input | 1 | Data cycle is read-modify-write |
| dc_read | input | 1 | Data cycle direction, 1 = read |
| dc_size | input | 2 | Data cycle size code |
| dc_fc | input | 3 | Data cycle function code |
| cap_strobe | input | 1 | Capture the status word |
| sw_out | output | 16 | Captured status word |
| rs_valid | input | 1 | Restore strobe on exception return |
| rs_flags | input | 4 | Stacked word bits 15:12 (C fault, B fault, C rerun, B rerun) |
| rs_super | input | 1 | Stacked privilege bit, 1 = supervisor |
| rr_valid | output | 1 | Refetch request offered |
| rr_ready | input | 1 | Bus accepts the request |
| rr_stage | output | 1 | Stage to refetch (0 = B, 1 = C) |
| rr_fc | output | 3 | Function code for the refetch |

## Verification
The capture strobe and a prefetch completion can fall in the same cycle, and that collision decides what the stacked word shows. The bench drives an errored stage B completion together with a capture. It expects the captured word to lack the new rerun bit and a second capture to show it. A consume request can likewise coincide with an armed stage, or a grant with the next arbitration. The cycle reference model judges both every clock.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int NSTG   = 2;
  localparam int SW_W   = 16;
  localparam int SZ_W   = 2;
  localparam int FC_W   = 3;
  localparam int STG_B  = 0;
  localparam int STG_C  = 1;
  localparam int SEL_W  = (NSTG > 1) ? $clog2(NSTG) : 1;
  localparam logic [FC_W-1:0] FC_UPROG = 3'b010;
  localparam logic [FC_W-1:0] FC_SPROG = 3'b110;

  typedef struct packed {
    logic            fault;
    logic            rmw;
    logic            rd;
    logic [SZ_W-1:0] size;
    logic [FC_W-1:0] fc;
  } dcyc_t;

  function automatic logic [SW_W-1:0] pack_word(
    input logic [NSTG-1:0] flt,
    input logic [NSTG-1:0] rr,
    input dcyc_t           d
  );
    return {flt[STG_C], flt[STG_B], rr[STG_C], rr[STG_B], 3'b000,
            d.fault, d.rmw, d.rd, d.size, 1'b0, d.fc};
  endfunction
endpackage

// File: rtl/pft_stage.sv
module pft_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_ok,
  input  logic fill_err,
  input  logic use_hit,
  input  logic restore,
  input  logic rs_rr,
  input  logic rs_flt,
  input  logic grant,
  output logic flt,
  output logic rr,
  output logic want
);
  logic inv_q, rr_q, flt_q, arm_q, want_q;
  logic inv_d, rr_d, flt_d, arm_d, want_d;
  logic upd_en;

  assign upd_en = restore | fill_ok | fill_err | use_hit | grant;

  always_comb begin
    inv_d  = inv_q;
    rr_d   = rr_q;
    flt_d  = flt_q;
    arm_d  = arm_q;
    want_d = want_q;
    if (restore) begin
      rr_d   = rs_rr;
      flt_d  = rs_rr & rs_flt;
      inv_d  = rs_rr;
      arm_d  = rs_rr & ~rs_flt;
      want_d = rs_rr & rs_flt;
    end else if (fill_ok) begin
      inv_d  = 1'b0;
      rr_d   = 1'b0;
      flt_d  = 1'b0;
      arm_d  = 1'b0;
      want_d = 1'b0;
    end else begin
      if (fill_err) begin
        inv_d = 1'b1;
        rr_d  = 1'b1;
      end
      if (grant) want_d = 1'b0;
      if (use_hit && inv_q) begin
        flt_d = 1'b1;
        rr_d  = 1'b1;
        if (arm_q) begin
          want_d = 1'b1;
          arm_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q  <= 1'b0;
      rr_q   <= 1'b0;
      flt_q  <= 1'b0;
      arm_q  <= 1'b0;
      want_q <= 1'b0;
    end else if (upd_en) begin
      inv_q  <= inv_d;
      rr_q   <= rr_d;
      flt_q  <= flt_d;
      arm_q  <= arm_d;
      want_q <= want_d;
    end
  end

  assign flt  = flt_q;
  assign rr   = rr_q;
  assign want = want_q;
endmodule

// File: rtl/pft_arb.sv
module pft_arb #(
  parameter int N     = 2,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     want,
  input  logic             ready,
  output logic             valid,
  output logic [SEL_W-1:0] sel,
  output logic [N-1:0]     grant
);
  logic             busy_q, busy_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [N-1:0]     avail;
  logic             load_en;

  for (genvar gi = 0; gi < N; gi++) begin : g_grant
    assign grant[gi] = busy_q & ready & (sel_q == SEL_W'(gi));
  end

  assign avail   = want & ~grant;
  assign load_en = ~busy_q | ready;

  always_comb begin
    busy_d = |avail;
    sel_d  = sel_q;
    for (int i = 0; i < N; i++) begin
      if (avail[i]) sel_d = SEL_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
    end else if (load_en) begin
      busy_q <= busy_d;
      sel_q  <= sel_d;
    end
  end

  assign valid = busy_q;
  assign sel   = sel_q;
endmodule

// File: rtl/pft_word.sv
module pft_word
  import pft_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dc_valid,
  input  dcyc_t           dc_in,
  input  logic            cap,
  input  logic [NSTG-1:0] flt_v,
  input  logic [NSTG-1:0] rr_v,
  output logic [SW_W-1:0] sw
);
  dcyc_t           dc_q;
  logic [SW_W-1:0] sw_q, sw_d;

  assign sw_d = pack_word(flt_v, rr_v, dc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dc_q <= '0;
    else if (dc_valid) dc_q <= dc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sw_q <= '0;
    else if (cap) sw_q <= sw_d;
  end

  assign sw = sw_q;
endmodule

// File: rtl/pf_fault_tracker.sv
module pf_fault_tracker
  import pft_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pf_done,
  input  logic            pf_err,
  input  logic            pf_stage,
  input  logic            use_req,
  input  logic            use_stage,
  input  logic            dc_valid,
  input  logic            dc_fault,
  input  logic            dc_rmw,
  input  logic            dc_read,
  input  logic [SZ_W-1:0] dc_size,
  input  logic [FC_W-1:0] dc_fc,
  input  logic            cap_strobe,
  output logic [SW_W-1:0] sw_out,
  input  logic            rs_valid,
  input  logic [3:0]      rs_flags,
  input  logic            rs_super,
  output logic            rr_valid,
  input  logic            rr_ready,
  output logic            rr_stage,
  output logic [FC_W-1:0] rr_fc
);
  logic            rst_s1_q, rst_s2_q;
  logic            priv_q;
  logic [NSTG-1:0] flt_v, rr_v, want_v, grant_v;
  logic [SEL_W-1:0] sel;
  dcyc_t           dc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q)     priv_q <= 1'b0;
    else if (rs_valid) priv_q <= rs_super;
  end

  for (genvar gs = 0; gs < NSTG; gs++) begin : g_stage
    logic hit_pf, hit_use;
    assign hit_pf  = pf_done & (pf_stage == 1'(gs));
    assign hit_use = use_req & (use_stage == 1'(gs));
    pft_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_s2_q),
      .fill_ok  (hit_pf & ~pf_err),
      .fill_err (hit_pf & pf_err),
      .use_hit  (hit_use),
      .restore  (rs_valid),
      .rs_rr    (rs_flags[gs]),
      .rs_flt   (rs_flags[gs+2]),
      .grant    (grant_v[gs]),
      .flt      (flt_v[gs]),
      .rr       (rr_v[gs]),
      .want     (want_v[gs])
    );
  end

  pft_arb #(.N(NSTG), .SEL_W(SEL_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .want  (want_v),
    .ready (rr_ready),
    .valid (rr_valid),
    .sel   (sel),
    .grant (grant_v)
  );

  assign dc_in = '{fault: dc_fault, rmw: dc_rmw, rd: dc_read, size: dc_size, fc: dc_fc};

  pft_word u_word (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .dc_valid (dc_valid),
    .dc_in    (dc_in),
    .cap      (cap_strobe),
    .flt_v    (flt_v),
    .rr_v     (rr_v),
    .sw       (sw_out)
  );

  assign rr_stage = sel[0];
  assign rr_fc    = priv_q ? FC_SPROG : FC_UPROG;
endmodule

// File: rtl/pft_checker.sv
module pft_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cap_strobe,
  input logic [15:0] sw_out,
  input logic        rr_valid,
  input logic        rr_ready,
  input logic        rr_stage,
  input logic [2:0]  rr_fc
);
  // R12: fault bit implies the matching rerun bit
  p_fault_has_rerun_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_out[15] || sw_out[13]) && (!sw_out[14] || sw_out[12]));

  // R5: reserved positions stay zero
  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_out[11:9] == 3'b000) && !sw_out[3]);

  // R5: word only changes after a capture
  p_word_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> $stable(sw_out));

  // R11: offer is held until accepted
  p_offer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && !rr_ready) |=> (rr_valid && $stable(rr_stage) && $stable(rr_fc)));

  // R9: only program-space codes are requested
  p_prog_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rr_valid |-> (rr_fc == 3'b110 || rr_fc == 3'b010));
endmodule

bind pf_fault_tracker pft_checker u_pft_checker (.*);

// File: tb/test_pf_fault_tracker.sv
module test_pf_fault_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_done = 0, pf_err = 0, pf_stage = 0, use_req = 0, use_stage = 0;
  logic dc_valid = 0, dc_fault = 0, dc_rmw = 0, dc_read = 0;
  logic [1:0] dc_size = 0;
  logic [2:0] dc_fc = 0;
  logic cap_strobe = 0, rs_valid = 0, rs_super = 0, rr_ready = 0;
  logic [3:0] rs_flags = 0;
  logic [15:0] sw_out;
  logic rr_valid, rr_stage;
  logic [2:0] rr_fc;

  int checks = 0, fails = 0;
  bit finished = 0, cmp_on = 0;

  always #2.5 clk = ~clk;

  pf_fault_tracker i_pf_fault_tracker (.*);

  // behavioural reference model
  bit m_inv[2], m_rr[2], m_flt[2], m_arm[2], m_want[2];
  bit m_busy, m_priv;
  int m_sel;
  bit [8:0] m_dc;
  bit [15:0] m_sw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_inv[s] = 0; m_rr[s] = 0; m_flt[s] = 0; m_arm[s] = 0; m_want[s] = 0;
      end
      m_busy = 0; m_priv = 0; m_sel = 0; m_dc = 0; m_sw = 0;
    end else begin
      bit g[2];
      bit cand[2];
      for (int s = 0; s < 2; s++) g[s] = m_busy && rr_ready && (m_sel == s);
      if (cap_strobe)
        m_sw = {m_flt[1], m_flt[0], m_rr[1], m_rr[0], 3'b000, m_dc[8:4], 1'b0, m_dc[2:0]};
      if (dc_valid) m_dc = {dc_fault, dc_rmw, dc_read, dc_size, 1'b0, dc_fc};
      if (!m_busy || rr_ready) begin
        for (int s = 0; s < 2; s++) cand[s] = m_want[s] && !g[s];
        m_busy = cand[0] || cand[1];
        if (cand[1]) m_sel = 1;
        else if (cand[0]) m_sel = 0;
      end
      for (int s = 0; s < 2; s++) begin
        bit fill, use_s, was_inv;
        fill    = pf_done && (pf_stage == s);
        use_s   = use_req && (use_stage == s);
        was_inv = m_inv[s];
        if (rs_valid) begin
          m_rr[s]   = rs_flags[s];
          m_flt[s]  = rs_flags[s] && rs_flags[s+2];
          m_inv[s]  = rs_flags[s];
          m_arm[s]  = rs_flags[s] && !rs_flags[s+2];
          m_want[s] = rs_flags[s] && rs_flags[s+2];
        end else if (fill && !pf_err) begin
          m_inv[s] = 0; m_rr[s] = 0; m_flt[s] = 0; m_arm[s] = 0; m_want[s] = 0;
        end else begin
          if (fill) begin m_inv[s] = 1; m_rr[s] = 1; end
          if (g[s]) m_want[s] = 0;
          if (use_s && was_inv) begin
            m_flt[s] = 1; m_rr[s] = 1;
            if (m_arm[s]) begin m_want[s] = 1; m_arm[s] = 0; end
          end
        end
      end
      if (rs_valid) m_priv = rs_super;
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R5 model word", sw_out, m_sw);
      chk("R6 model valid", 16'(rr_valid), 16'(m_busy));
      if (m_busy) begin
        chk("R10 model stage", 16'(rr_stage), 16'(m_sel));
        chk("R9 model fc", 16'(rr_fc), m_priv ? 16'h6 : 16'h2);
      end
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      pf_done = 0; pf_err = 0; use_req = 0; dc_valid = 0;
      cap_strobe = 0; rs_valid = 0;
    end
  endtask

  task automatic capture();
    cap_strobe = 1; step();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(4);
    cmp_on = 1;
    chk("R1 reset word", sw_out, 16'h0000);
    chk("R1 reset valid", 16'(rr_valid), 16'h0);

    // data attributes then capture
    dc_valid = 1; dc_fault = 1; dc_rmw = 1; dc_read = 1; dc_size = 2'b10; dc_fc = 3'b101;
    step();
    capture();
    chk("R5 layout", sw_out, 16'h01E5);

    // errored prefetch into C
    pf_done = 1; pf_err = 1; pf_stage = 1; step();
    capture();
    chk("R2 rerun C", sw_out, 16'h21E5);

    // consume invalid C
    use_req = 1; use_stage = 1; step();
    capture();
    chk("R3 fault C", sw_out, 16'hA1E5);
    step(3);
    chk("R5 hold", sw_out, 16'hA1E5);

    // good fill clears C
    pf_done = 1; pf_err = 0; pf_stage = 1; step();
    capture();
    chk("R4 clear C", sw_out, 16'h01E5);

    // capture collides with errored fill of B
    pf_done = 1; pf_err = 1; pf_stage = 0; cap_strobe = 1; step();
    chk("R5 same-cycle capture", sw_out, 16'h01E5);
    capture();
    chk("R2 rerun B", sw_out, 16'h11E5);

    // restore: B fault+rerun, C rerun only, supervisor
    rs_valid = 1; rs_flags = 4'b0111; rs_super = 1; step();
    chk("R6 not yet", 16'(rr_valid), 16'h0);
    step();
    chk("R6 offer B", 16'(rr_valid), 16'h1);
    chk("R6 stage B", 16'(rr_stage), 16'h0);
    chk("R9 super fc", 16'(rr_fc), 16'h6);
    step(3);
    chk("R11 held", 16'({rr_valid, rr_stage}), 16'h2);
    rr_ready = 1; step(); rr_ready = 0;
    chk("R7 no C request", 16'(rr_valid), 16'h0);
    step(3);
    chk("R7 still none", 16'(rr_valid), 16'h0);
    use_req = 1; use_stage = 1; step(); step();
    chk("R7 offer C", 16'({rr_valid, rr_stage}), 16'h3);
    rr_ready = 1; step(); rr_ready = 0;
    chk("R11 accepted", 16'(rr_valid), 16'h0);

    // restore both stages, user
    rs_valid = 1; rs_flags = 4'b1111; rs_super = 0; step(); step();
    chk("R10 C first", 16'({rr_valid, rr_stage}), 16'h3);
    chk("R9 user fc", 16'(rr_fc), 16'h2);
    rr_ready = 1; step();
    chk("R10 then B", 16'({rr_valid, rr_stage}), 16'h2);
    step(); rr_ready = 0;
    chk("R10 done", 16'(rr_valid), 16'h0);

    // restore with B fault but no rerun
    rs_valid = 1; rs_flags = 4'b0100; step(4);
    chk("R8 no request", 16'(rr_valid), 16'h0);
    use_req = 1; use_stage = 0; step();
    use_req = 1; use_stage = 1; step();
    capture();
    chk("R12 flags clear", 16'(sw_out[15:12]), 16'h0);
    chk("R8 valid stages", sw_out, 16'h01E5);

    step(2);
    finish_run();
  end
endmodule